// File: doc/BRIEF.md
# Multi-Channel Output Compare Timer

A timer peripheral with one free-running 16-bit counter and eight output compare channels. A prescaler sets the counter's tick rate. It has two modes: a power-of-two divider, or a precision divider that divides by any value from 1 to 256. Each channel holds a 16-bit compare value. On the tick at which the counter reaches that value, the channel raises its flag. It then acts on its output pin in one of four ways: leave it, toggle it, drive it low or drive it high. Firmware schedules an event by reading the counter, adding a delay modulo 2^16 and writing the sum to a channel.

Software reaches the block through a byte-wide register bus with synchronous writes and combinational reads. Each 16-bit compare value is written as two bytes and takes effect only when the low byte arrives. Channel flags can be cleared in two ways. The default is write-one-to-clear. In fast-clear mode, writing a channel's compare value clears that channel's flag. On a counter wrap, the block sets an overflow flag and can toggle selected pins. An interrupt output combines the enabled channel flags.

Register offsets: 0x00 compare-mode select, 0x01 interrupt enable, 0x02 wrap-toggle select, 0x03 control, 0x04 standard divider code, 0x05 precision divider value, 0x06/0x07 pin actions, 0x08 channel flags, 0x09 overflow flag, 0x0A/0x0B counter high/low. Channel n's compare value sits at 0x10+2n (high byte) and 0x11+2n (low byte). All of these read back.

Top module: `oc_timer`

## Requirements
- R1: After reset the counter, the prescaler, all pins, all flags, the interrupt output and every configuration register are zero.
- R2: Control bit 0 at 0x03 (run) is the only enable for the counter. While it is set, the counter advances by one on each prescaler tick. While it is clear, the counter holds. With control bit 2 clear, a tick occurs every 2^k clocks, where k is bits 2:0 of 0x04. The counter reads back at 0x0A (high) and 0x0B (low).
- R3: With control bit 2 set (precision mode), a tick occurs every v+1 clocks, where v is the byte at 0x05.
- R4: A channel matches on the tick at which the counter becomes equal to its committed compare value, but only if its bit in 0x00 is set. On that clock edge its flag bit n at 0x08 sets. A channel whose 0x00 bit is clear never matches.
- R5: On a match, a channel applies its 2-bit action: 00 leaves the pin, 01 toggles it, 10 drives it low, 11 drives it high. Channel n uses bits [2(n mod 4)+1 : 2(n mod 4)] of 0x06 for n < 4, and of 0x07 otherwise.
- R6: Compare values are compared modulo 2^16. A value equal to the counter plus 0xFFFF at the moment its low byte is written fires exactly 65535 ticks after that write.
- R7: Writing the high byte of a compare value only stages it. The channel keeps its old value, and the staged byte is not visible at the readback address, until the low byte is written.
- R8: With control bit 1 (fast clear) clear, writing 0x08 clears each flag whose written bit is 1 and leaves the others.
- R9: With fast clear set, writes to 0x08 have no effect, and writing a channel's low compare byte clears that channel's flag.
- R10: When the counter wraps from 0xFFFF to 0x0000, bit 7 of 0x09 sets, and every pin whose bit in 0x02 is set toggles. A match with a non-00 action on that same tick overrides the toggle. Bit 7 of 0x09 is cleared by writing 1 to it.
- R11: The interrupt output is high exactly when some channel has both its flag and its enable bit in 0x01 set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busWr | input | 1 | Write strobe for the register bus |
| busAddr | input | 5 | Byte address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr (combinational) |
| pinOut | output | 8 | Channel output pins |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default values: eight channels, a 16-bit counter and an 8-bit prescaler. It runs the divider tests at small ratios and switches to divide-by-one for the compare tests. At divide-by-one, a full 65535-tick schedule and the counter wrap both fit in about 66k clocks. That lets the bench observe the 0xFFFF offset, the overflow toggle and the case where a match and the wrap fall on the same tick.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CH_N     = 8;
  localparam int CNT_W    = 16;
  localparam int BYTE_W   = 8;
  localparam int PRE_W    = 8;
  localparam int DIVC_W   = 3;
  localparam int ACT_W    = 2;
  localparam int ADDR_W   = 5;
  localparam int CH_IDX_W = $clog2(CH_N);

  localparam logic [ADDR_W-1:0] REG_OC    = 5'h00;
  localparam logic [ADDR_W-1:0] REG_IE    = 5'h01;
  localparam logic [ADDR_W-1:0] REG_OVT   = 5'h02;
  localparam logic [ADDR_W-1:0] REG_CTRL  = 5'h03;
  localparam logic [ADDR_W-1:0] REG_DIV   = 5'h04;
  localparam logic [ADDR_W-1:0] REG_PDIV  = 5'h05;
  localparam logic [ADDR_W-1:0] REG_ACTL  = 5'h06;
  localparam logic [ADDR_W-1:0] REG_ACTH  = 5'h07;
  localparam logic [ADDR_W-1:0] REG_FLG   = 5'h08;
  localparam logic [ADDR_W-1:0] REG_OVF   = 5'h09;
  localparam logic [ADDR_W-1:0] REG_CNTH  = 5'h0A;
  localparam logic [ADDR_W-1:0] REG_CNTL  = 5'h0B;
  localparam logic [ADDR_W-1:0] CMP_BASE  = 5'h10;

  typedef enum logic [ACT_W-1:0] {
    ACT_HOLD   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } actE;

  typedef struct packed {
    logic                    run;
    logic                    fastClr;
    logic                    precise;
    logic [DIVC_W-1:0]       divCode;
    logic [PRE_W-1:0]        precDiv;
    logic [CH_N-1:0]         ocSel;
    logic [CH_N-1:0]         ovfTog;
    logic [CH_N*ACT_W-1:0]   act;
  } cfgT;

  typedef struct packed {
    logic [CH_N-1:0]  cmpLoad;
    logic [CNT_W-1:0] cmpValue;
    logic [CH_N-1:0]  flagClr;
    logic             ovfClr;
  } strobeT;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        busWr,
  input  logic [ADDR_W-1:0]           busAddr,
  input  logic [BYTE_W-1:0]           busWdata,
  input  logic [CNT_W-1:0]            cntVal,
  input  logic [CH_N-1:0]             flagVal,
  input  logic                        ovfVal,
  input  logic [CH_N-1:0][CNT_W-1:0]  cmpVal,
  output cfgT                         cfg,
  output strobeT                      stb,
  output logic [BYTE_W-1:0]           busRdata,
  output logic                        irq
);
  logic [CH_N-1:0]    irqEn;
  logic [BYTE_W-1:0]  holdHi;
  logic               inCmp;
  logic [ADDR_W-1:0]  cmpOff;
  logic [CH_IDX_W-1:0] chSel;
  logic               isLowByte;

  assign inCmp     = busAddr >= CMP_BASE;
  assign cmpOff    = busAddr - CMP_BASE;
  assign chSel     = CH_IDX_W'(cmpOff >> 1);
  assign isLowByte = cmpOff[0];

  // Configuration registers and the staged high compare byte
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg    <= '0;
      irqEn  <= '0;
      holdHi <= '0;
    end else if (busWr) begin
      if (inCmp) begin
        if (!isLowByte) holdHi <= busWdata;
      end else begin
        case (busAddr)
          REG_OC:   cfg.ocSel   <= busWdata;
          REG_IE:   irqEn       <= busWdata;
          REG_OVT:  cfg.ovfTog  <= busWdata;
          REG_CTRL: {cfg.precise, cfg.fastClr, cfg.run} <= busWdata[2:0];
          REG_DIV:  cfg.divCode <= busWdata[DIVC_W-1:0];
          REG_PDIV: cfg.precDiv <= busWdata;
          REG_ACTL: cfg.act[BYTE_W-1:0]        <= busWdata;
          REG_ACTH: cfg.act[2*BYTE_W-1:BYTE_W] <= busWdata;
          default: ;
        endcase
      end
    end
  end

  // Strobes towards the datapath
  always_comb begin
    stb          = '0;
    stb.cmpValue = {holdHi, busWdata};
    if (busWr) begin
      if (inCmp) begin
        if (isLowByte) begin
          stb.cmpLoad[chSel] = 1'b1;
          if (cfg.fastClr) stb.flagClr[chSel] = 1'b1;
        end
      end else if (busAddr == REG_FLG) begin
        if (!cfg.fastClr) stb.flagClr = busWdata;
      end else if (busAddr == REG_OVF) begin
        stb.ovfClr = busWdata[BYTE_W-1];
      end
    end
  end

  // Read mux
  always_comb begin
    busRdata = '0;
    if (inCmp) begin
      busRdata = isLowByte ? cmpVal[chSel][BYTE_W-1:0] : cmpVal[chSel][CNT_W-1:BYTE_W];
    end else begin
      case (busAddr)
        REG_OC:   busRdata = cfg.ocSel;
        REG_IE:   busRdata = irqEn;
        REG_OVT:  busRdata = cfg.ovfTog;
        REG_CTRL: busRdata = {5'b0, cfg.precise, cfg.fastClr, cfg.run};
        REG_DIV:  busRdata = {{(BYTE_W-DIVC_W){1'b0}}, cfg.divCode};
        REG_PDIV: busRdata = cfg.precDiv;
        REG_ACTL: busRdata = cfg.act[BYTE_W-1:0];
        REG_ACTH: busRdata = cfg.act[2*BYTE_W-1:BYTE_W];
        REG_FLG:  busRdata = flagVal;
        REG_OVF:  busRdata = {ovfVal, {(BYTE_W-1){1'b0}}};
        REG_CNTH: busRdata = cntVal[CNT_W-1:BYTE_W];
        REG_CNTL: busRdata = cntVal[BYTE_W-1:0];
        default:  busRdata = '0;
      endcase
    end
  end

  assign irq = |(flagVal & irqEn);
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst,
  input  cfgT                         cfg,
  input  strobeT                      stb,
  output logic [CNT_W-1:0]            cnt,
  output logic [CH_N-1:0][CNT_W-1:0]  cmpRegs,
  output logic [CH_N-1:0]             flags,
  output logic                        ovfFlag,
  output logic [CH_N-1:0]             pins
);
  localparam int STD_W = PRE_W + 1;

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preLim;
  logic [STD_W-1:0] stdDiv;
  logic             tick;
  logic             wrapNow;
  logic [CNT_W-1:0] cntNext;
  logic [CH_N-1:0]  hit;
  logic [CH_N-1:0]  pinNxt;

  assign stdDiv  = STD_W'(1) << cfg.divCode;
  assign preLim  = cfg.precise ? cfg.precDiv : PRE_W'(stdDiv - STD_W'(1));
  assign tick    = cfg.run && (preCnt >= preLim);
  assign cntNext = cnt + CNT_W'(1);
  assign wrapNow = tick && (cnt == '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      preCnt <= '0;
      cnt    <= '0;
    end else if (cfg.run) begin
      preCnt <= tick ? '0 : preCnt + PRE_W'(1);
      if (tick) cnt <= cntNext;
    end
  end

  // Match detection and next pin state; a compare action beats the wrap toggle
  always_comb begin
    for (int c = 0; c < CH_N; c++) begin
      hit[c]    = tick && cfg.ocSel[c] && (cmpRegs[c] == cntNext);
      pinNxt[c] = pins[c];
      if (hit[c] && (actE'(cfg.act[ACT_W*c +: ACT_W]) != ACT_HOLD)) begin
        case (actE'(cfg.act[ACT_W*c +: ACT_W]))
          ACT_TOGGLE: pinNxt[c] = ~pins[c];
          ACT_CLEAR:  pinNxt[c] = 1'b0;
          ACT_SET:    pinNxt[c] = 1'b1;
          default:    pinNxt[c] = pins[c];
        endcase
      end else if (wrapNow && cfg.ovfTog[c]) begin
        pinNxt[c] = ~pins[c];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmpRegs <= '0;
      flags   <= '0;
      ovfFlag <= 1'b0;
      pins    <= '0;
    end else begin
      for (int c = 0; c < CH_N; c++) begin
        if (stb.cmpLoad[c]) cmpRegs[c] <= stb.cmpValue;
      end
      flags   <= (flags & ~stb.flagClr) | hit;
      ovfFlag <= (ovfFlag & ~stb.ovfClr) | wrapNow;
      pins    <= pinNxt;
    end
  end

  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst)
    !cfg.run |=> $stable(cnt)); // R2
  AST_STEP_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    tick |=> cnt == $past(cnt) + CNT_W'(1)); // R2
  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt == '1) |=> ovfFlag); // R10

  for (genvar g = 0; g < CH_N; g++) begin : gChk
    AST_FLAG_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
      hit[g] |=> flags[g]); // R4
    AST_PIN_SET: assert property (@(posedge clk) disable iff (rst)
      (hit[g] && cfg.act[ACT_W*g +: ACT_W] == 2'b11) |=> pins[g]); // R5
    AST_PIN_CLEAR: assert property (@(posedge clk) disable iff (rst)
      (hit[g] && cfg.act[ACT_W*g +: ACT_W] == 2'b10) |=> !pins[g]); // R5
    AST_CMP_STABLE: assert property (@(posedge clk) disable iff (rst)
      !stb.cmpLoad[g] |=> $stable(cmpRegs[g])); // R7
  end
endmodule

// File: rtl/oc_timer.sv
module oc_timer
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BYTE_W-1:0] busWdata,
  output logic [BYTE_W-1:0] busRdata,
  output logic [CH_N-1:0]   pinOut,
  output logic              irq
);
  cfgT                        cfg;
  strobeT                     stb;
  logic [CNT_W-1:0]           cnt;
  logic [CH_N-1:0][CNT_W-1:0] cmpRegs;
  logic [CH_N-1:0]            flags;
  logic                       ovfFlag;

  tmr_ctrl uCtrl (
    .clk(clk), .rst(rst), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .cntVal(cnt), .flagVal(flags), .ovfVal(ovfFlag), .cmpVal(cmpRegs),
    .cfg(cfg), .stb(stb), .busRdata(busRdata), .irq(irq)
  );

  tmr_datapath uPath (
    .clk(clk), .rst(rst), .cfg(cfg), .stb(stb),
    .cnt(cnt), .cmpRegs(cmpRegs), .flags(flags), .ovfFlag(ovfFlag), .pins(pinOut)
  );
endmodule

// File: tb/oc_timer_test.sv
`timescale 1ns/1ps
module oc_timer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       busWr = 1'b0;
  logic [4:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic [7:0] pinOut;
  logic       irq;

  int nChk = 0;
  int nBad = 0;
  int cyc = 0;
  bit done = 0;

  // reference model state
  int       mPre, mCnt;
  int       mCmp[8];
  bit [7:0] mOc, mIe, mOvt, mDiv, mPdiv, mFlg, mHold, mPin;
  bit       mRun, mFast, mPrec, mOvf;
  bit [15:0] mAct;

  oc_timer uut (
    .clk(clk), .rst(rst), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .pinOut(pinOut), .irq(irq)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin : model
    int lim, nxt, a;
    bit tk, wrap;
    bit [7:0] hitV;
    if (rst) begin
      mPre = 0; mCnt = 0; mOc = 0; mIe = 0; mOvt = 0; mDiv = 0; mPdiv = 0;
      mFlg = 0; mHold = 0; mPin = 0; mRun = 0; mFast = 0; mPrec = 0; mOvf = 0; mAct = 0;
      for (int c = 0; c < 8; c++) mCmp[c] = 0;
    end else begin
      lim  = mPrec ? int'(mPdiv) : (1 << mDiv[2:0]) - 1;
      tk   = mRun && (mPre >= lim);
      hitV = 0;
      wrap = 0;
      if (tk) begin
        nxt  = (mCnt + 1) % 65536;
        wrap = (mCnt == 65535);
        for (int c = 0; c < 8; c++) begin
          bit [1:0] ac;
          ac = mAct[2*c +: 2];
          if (mOc[c] && mCmp[c] == nxt) hitV[c] = 1;
          if (hitV[c] && ac != 0) begin
            if (ac == 1) mPin[c] = ~mPin[c];
            else if (ac == 2) mPin[c] = 0;
            else mPin[c] = 1;
          end else if (wrap && mOvt[c]) begin
            mPin[c] = ~mPin[c];
          end
        end
        mCnt = nxt;
      end
      if (mRun) mPre = tk ? 0 : mPre + 1;
      if (busWr) begin
        a = busAddr;
        if (a >= 16) begin
          if (a % 2 == 1) begin
            mCmp[(a-16)/2] = mHold * 256 + busWdata;
            if (mFast) mFlg[(a-16)/2] = 0;
          end else mHold = busWdata;
        end else begin
          case (a)
            0: mOc = busWdata;
            1: mIe = busWdata;
            2: mOvt = busWdata;
            3: {mPrec, mFast, mRun} = busWdata[2:0];
            4: mDiv = busWdata & 8'h07;
            5: mPdiv = busWdata;
            6: mAct[7:0] = busWdata;
            7: mAct[15:8] = busWdata;
            8: if (!mFast) mFlg = mFlg & ~busWdata;
            9: if (busWdata[7]) mOvf = 0;
            default: ;
          endcase
        end
      end
      mFlg = mFlg | hitV;
      if (wrap) mOvf = 1;
    end
  end

  function automatic bit [7:0] mRead(int a);
    bit [7:0] r;
    if (a >= 16) r = (a % 2 == 1) ? 8'(mCmp[(a-16)/2] & 255) : 8'(mCmp[(a-16)/2] >> 8);
    else case (a)
      0: r = mOc;
      1: r = mIe;
      2: r = mOvt;
      3: r = {5'b0, mPrec, mFast, mRun};
      4: r = mDiv;
      5: r = mPdiv;
      6: r = mAct[7:0];
      7: r = mAct[15:8];
      8: r = mFlg;
      9: r = {mOvf, 7'b0};
      10: r = 8'(mCnt >> 8);
      11: r = 8'(mCnt & 255);
      default: r = 0;
    endcase
    return r;
  endfunction

  task automatic summary();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  // every-clock comparison of pins and interrupt (R4 R5 R10 R11)
  always @(negedge clk) begin
    if (!rst && !done) begin
      nChk++;
      if (pinOut !== mPin || irq !== |(mFlg & mIe)) begin
        nBad++;
        $display("FAIL R4 R5 R10 R11 per-clock: pins=%h irq=%b expected pins=%h irq=%b",
                 pinOut, irq, mPin, |(mFlg & mIe));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual=%0d cycles expected=finish", cyc);
      summary();
    end
  end

  task automatic chk(string tag, int act, int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(int a, output int v);
    busAddr = 5'(a);
    #1;
    v = busRdata;
  endtask

  task automatic rdChk(int a, string tag);
    int v;
    rd(a, v);
    chk(tag, v, mRead(a));
  endtask

  task automatic wr(int a, int d);
    busAddr = 5'(a); busWdata = 8'(d); busWr = 1;
    @(posedge clk);
    @(negedge clk);
    busWr = 0;
  endtask

  task automatic rdCnt(output int v);
    int h, l;
    rd(10, h); rd(11, l);
    v = h * 256 + l;
  endtask

  task automatic wrCmp(int ch, int val);
    wr(16 + 2*ch, (val >> 8) & 255);
    wr(17 + 2*ch, val & 255);
  endtask

  initial begin
    int v, c0, c1, t, n;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    rd(11, v); chk("R1 counter low", v, 0);
    rd(10, v); chk("R1 counter high", v, 0);
    rd(8, v);  chk("R1 flags", v, 0);
    rd(3, v);  chk("R1 control", v, 0);
    chk("R1 pins", pinOut, 0);
    chk("R1 irq", irq, 0);

    // R2 standard divider by 4, then stopped
    wr(4, 2); wr(3, 1);
    rd(11, c0); repeat (40) @(negedge clk); rd(11, c1);
    chk("R2 divide by 4", c1 - c0, 10);
    wr(3, 0);
    rd(11, c0); repeat (20) @(negedge clk); rd(11, c1);
    chk("R2 held while stopped", c1 - c0, 0);

    // R3 precision divider by 3
    wr(5, 2); wr(3, 5);
    rd(11, c0); repeat (30) @(negedge clk); rd(11, c1);
    chk("R3 divide by 3", c1 - c0, 10);

    // compare channels at divide by 1
    wr(3, 1); wr(4, 0);
    wr(0, 8'hFD); wr(1, 8'h01); wr(6, 8'hBD); wr(7, 8'hCF);
    rdCnt(c0);
    t = (c0 + 20) & 16'hFFFF;
    for (int ch = 0; ch < 4; ch++) wrCmp(ch, t);
    repeat (30) @(negedge clk);
    chk("R5 toggle ch0", pinOut[0], 1);
    chk("R4 ch1 not in compare mode", pinOut[1], 0);
    chk("R5 set ch2", pinOut[2], 1);
    chk("R5 clear ch3", pinOut[3], 0);
    rd(8, v); chk("R4 flags after match", v, 8'h0D);
    chk("R11 irq from ch0", irq, 1);
    rdCnt(c0);
    wrCmp(0, (c0 + 10) & 16'hFFFF);
    repeat (15) @(negedge clk);
    chk("R5 toggle back ch0", pinOut[0], 0);

    // R8 write-one-to-clear
    wr(8, 0); rd(8, v); chk("R8 zero bits keep flags", v, 8'h0D);
    wr(8, 1); rd(8, v); chk("R8 clear ch0", v, 8'h0C);
    chk("R11 irq drops with flag", irq, 0);

    // R7 staged high byte
    rdCnt(c0);
    t = (c0 + 300) & 16'hFFFF;
    wr(24, t >> 8);
    repeat (20) @(negedge clk);
    rd(24, v); chk("R7 old value kept", v, 0);
    rdChk(24, "R7 readback model");
    chk("R7 no fire before commit", pinOut[4], 0);
    wr(25, t & 255);
    rd(24, v); chk("R7 high byte committed", v, t >> 8);
    rd(25, v); chk("R7 low byte committed", v, t & 255);
    repeat (300) @(negedge clk);
    chk("R7 fires after commit", pinOut[4], 1);

    // R9 fast clear
    wr(3, 3);
    wr(8, 8'hFF); rd(8, v); chk("R9 write to flags ignored", v, 8'h1C);
    rdCnt(c0);
    wrCmp(3, (c0 + 1000) & 16'hFFFF);
    rd(8, v); chk("R9 compare write clears flag", v, 8'h14);
    wr(3, 1);

    // R10 preparation: ch7 driven high, then parked at 0 with wrap toggle
    rdCnt(c0);
    wrCmp(7, (c0 + 10) & 16'hFFFF);
    repeat (15) @(negedge clk);
    chk("R5 set ch7", pinOut[7], 1);
    wr(2, 8'hC0);
    wrCmp(7, 0);

    // R6 offset of 0xFFFF
    rdCnt(c0);
    wr(26, (c0 >> 8) & 255);
    wr(27, c0 & 255);
    n = 1;
    while (!pinOut[5] && n < 70000) begin
      @(negedge clk);
      n++;
    end
    chk("R6 0xFFFF offset delay", n, 65535);

    // R10 wrap effects
    chk("R10 wrap toggles ch6", pinOut[6], 1);
    chk("R10 compare action beats wrap toggle", pinOut[7], 1);
    rd(9, v); chk("R10 overflow flag", v, 8'h80);
    wr(9, 8'h80); rd(9, v); chk("R10 overflow flag cleared", v, 0);
    rdChk(10, "R2 counter high readback");
    rdChk(11, "R2 counter low readback");
    rdChk(8, "R4 flag readback");

    summary();
  end
endmodule